// File: doc/BRIEF.md
# Clock-Generator Control Register Slave on SMBus

This block is the configuration port of a system clock generator. It is a slave on a two-wire SMBus-style bus and keeps a small bank of eight 8-bit control bytes. The bytes switch individual clock outputs on and off, choose which outputs react to the stop request, choose whether outputs float or stay driven in power-down, and set spread spectrum, the serial reference frequency and the test modes. Each byte field is brought out as its own port, so the clock logic next to it reads the fields directly.

A host reaches the bank in two ways. Bit 7 of the command byte selects the mode. With bit 7 set, the transfer is a single-byte access at the offset held in bits 6:0. With bit 7 clear, the transfer is a block access that walks the bank upward from byte 0 and carries a byte-count field. Byte 0 shows the two strap pins sampled at power-up. Byte 7 shows an identification byte taken from an input. Both are read-only.

The serial clock and data lines are sampled with the system clock. The slave pulls the data line low by raising `sdaOe`, and pad logic outside the block turns that into an open-drain driver.

Top module: `clkcfg_smbus_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address 0x69, which is 0xD2 for a write and 0xD3 for a read once the direction bit is appended. After any other address it gives no acknowledge, never drives the data line, and ignores the rest of that transfer.
- R2: In a byte write, command bit 7 is 1 and command bits 6:0 give the offset. The following data byte is stored at that offset, and each of the three bytes is acknowledged.
- R3: In a block write, command bit 7 is 0. The next byte is a count and its value is ignored. The data bytes after it go to offsets 0, 1, 2 and upward in order, and every byte is acknowledged.
- R4: In a byte read, the host writes the command, sends a repeated start and then address 0xD3. The slave returns the byte at the offset, most significant bit first.
- R5: In a block read, the host writes command 0x00, sends a repeated start and then 0xD3. The slave returns the count 8 first, then bytes 0 to 7 in order. It keeps sending for as long as the host acknowledges.
- R6: After reset, bytes 1 to 6 read 0x7F, 0x00, 0xFF, 0x47, 0xDF and 0x03, and the data line is released.
- R7: Byte 0 reads {6'b0, strap[1:0]} and byte 7 reads the ID input. Writes to offsets 0, 7 and anything above 7 are acknowledged and discarded. Reads above offset 7 return 0x00.
- R8: The output ports decode the bytes as follows:
  - byte1: [7] serial-ref stop enable, [6] serial-ref enable, [2:0] host pairs 2..0 enable.
  - byte2: [7] serial-ref float in power-down, [6] serial-ref float on stop, [5:3] host pairs 2..0 float in power-down.
  - byte3: [7] software stop, [6:0] bus clocks 6..0 enable.
  - byte4: [7] USB normal drive, [6] USB enable, [5:3] free-running bus clocks 2..0 stop enable, [2:0] their enables.
  - byte5: [7] pixel 48 MHz enable, [6] host pair 3 enable, [5] mid output 4 alternate select, [4:0] mid clocks 4..0 enable.
  - byte6: [7] test clock mode, [5] strap test mode, [4] fast serial-ref, [2] spread on, [1:0] reference outputs 1..0 enable.
- R9: A stop or a repeated start after any complete byte ends the transfer. Bytes already acknowledged stay written, and the next transfer works normally.
- R10: `sdaOe` changes only just after a detected SCL falling edge, a start or a stop. It is low while the slave is idle or ignoring a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| sdaOe | output | 1 | 1 pulls the data line low |
| strapSel | input | 2 | Strap values sampled at power-up, read in byte 0 |
| idByte | input | 8 | Identification byte, read in byte 7 |
| hostEn | output | 4 | Host differential pair enables 3..0 |
| serRefEn | output | 1 | Serial reference pair enable |
| midEn | output | 5 | 66 MHz output enables 4..0 |
| midAltSel | output | 1 | Mid output 4 runs at 48 MHz when 1 |
| busEn | output | 7 | 33 MHz bus clock enables 6..0 |
| busFreeEn | output | 3 | Free-running bus clock enables 2..0 |
| refEn | output | 2 | Reference clock enables 1..0 |
| usb48En | output | 1 | USB 48 MHz output enable |
| pix48En | output | 1 | Pixel 48 MHz output enable |
| serRefStopEn | output | 1 | Serial reference stops on stop request |
| busFreeStopEn | output | 3 | Free-running bus clocks stop on stop request |
| busSwStop | output | 1 | Software stop request |
| serRefStopTri | output | 1 | Serial reference floats while stopped |
| serRefPdTri | output | 1 | Serial reference floats in power-down |
| hostPdTri | output | 3 | Host pairs 2..0 float in power-down |
| usb48NormDrive | output | 1 | USB output normal drive strength |
| spreadOn | output | 1 | Spread spectrum on |
| serRefFast | output | 1 | Serial reference at the higher frequency |
| strapTestMode | output | 1 | Strap inputs used as test selection |
| testClkMode | output | 1 | Test clock mode |

## Verification
The assertions check two things on every cycle. The data-line driver moves only right after an SCL fall, a start or a stop, and it stays off while the slave is idle or ignoring a transfer. The bank pointer and the storage also obey their rules on every cycle: it steps by one per stepped byte, a write lands at the pointed offset, and a write aimed at a read-only or missing offset leaves every writable byte unchanged. Only the bench scenarios can show the protocol-level behaviour:
- which addresses are acknowledged;
- the count-then-data order of a block read and the most-significant-bit-first bit order;
- reset contents and field positions on the output ports;
- that a transfer cut short after some bytes keeps exactly the bytes completed before the cut.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

  // Command offsets are 7 bits wide.
  localparam int PTR_W = 7;

  typedef struct packed {
    logic             ptrLoad;
    logic [PTR_W-1:0] ptrVal;
    logic             ptrInc;
    logic             regWr;
    logic [7:0]       wrData;
  } strobe_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_CNT,
    ST_CNT_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_HOLD
  } smb_state_t;

  function automatic logic [7:0] regDefault(input int idx);
    case (idx)
      1:       return 8'h7F;
      2:       return 8'h00;
      3:       return 8'hFF;
      4:       return 8'h47;
      5:       return 8'hDF;
      6:       return 8'h03;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic              sclPrev;
  logic              sdaPrev;

  // Synchronizer stages, idle-high after reset.
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sclPipe[s] <= 1'b1;
        sdaPipe[s] <= 1'b1;
      end else if (s == 0) begin
        sclPipe[s] <= sclIn;
        sdaPipe[s] <= sdaIn;
      end else begin
        sclPipe[s] <= sclPipe[(s == 0) ? 0 : s-1];
        sdaPipe[s] <= sdaPipe[(s == 0) ? 0 : s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  assign sclLvl   = sclPipe[STAGES-1];
  assign sdaLvl   = sdaPipe[STAGES-1];
  assign sclRise  = sclLvl & ~sclPrev;
  assign sclFall  = ~sclLvl & sclPrev;
  assign startDet = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopDet  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h69,
  parameter logic [7:0] BLOCK_COUNT = 8'd8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaLvl,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic [7:0] rdByte,
  output strobe_t    strb,
  output logic       sdaOe
);

  smb_state_t state;
  logic [3:0] bitCnt;
  logic [7:0] rxShift;
  logic [7:0] txShift;
  logic       readReq;
  logic       blockMode;
  logic       rdIsData;

  wire byteIn = (bitCnt == 4'd8);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      rxShift   <= '0;
      txShift   <= '0;
      readReq   <= 1'b0;
      blockMode <= 1'b0;
      rdIsData  <= 1'b0;
      sdaOe     <= 1'b0;
      strb      <= '0;
    end else begin
      strb <= '0;
      if (startDet) begin
        state  <= ST_ADDR;
        bitCnt <= '0;
        sdaOe  <= 1'b0;
      end else if (stopDet) begin
        state  <= ST_IDLE;
        bitCnt <= '0;
        sdaOe  <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_CMD, ST_CNT, ST_WDATA: begin
            if (sclRise) begin
              rxShift <= {rxShift[6:0], sdaLvl};
              bitCnt  <= bitCnt + 4'd1;
            end else if (sclFall && byteIn) begin
              bitCnt <= '0;
              case (state)
                ST_ADDR: begin
                  if (rxShift[7:1] == SLAVE_ADDR) begin
                    sdaOe   <= 1'b1;
                    readReq <= rxShift[0];
                    state   <= ST_ADDR_ACK;
                  end else begin
                    state <= ST_HOLD;
                  end
                end
                ST_CMD: begin
                  sdaOe        <= 1'b1;
                  blockMode    <= ~rxShift[7];
                  strb.ptrLoad <= 1'b1;
                  strb.ptrVal  <= rxShift[7] ? rxShift[PTR_W-1:0] : '0;
                  state        <= ST_CMD_ACK;
                end
                ST_CNT: begin
                  sdaOe <= 1'b1;
                  state <= ST_CNT_ACK;
                end
                default: begin
                  sdaOe       <= 1'b1;
                  strb.regWr  <= 1'b1;
                  strb.wrData <= rxShift;
                  strb.ptrInc <= 1'b1;
                  state       <= ST_WDATA_ACK;
                end
              endcase
            end
          end
          ST_ADDR_ACK: begin
            if (sclFall) begin
              if (readReq) begin
                if (blockMode) begin
                  txShift  <= BLOCK_COUNT;
                  sdaOe    <= ~BLOCK_COUNT[7];
                  rdIsData <= 1'b0;
                end else begin
                  txShift  <= rdByte;
                  sdaOe    <= ~rdByte[7];
                  rdIsData <= 1'b1;
                end
                state <= ST_RD;
              end else begin
                sdaOe <= 1'b0;
                state <= ST_CMD;
              end
            end
          end
          ST_CMD_ACK: begin
            if (sclFall) begin
              sdaOe <= 1'b0;
              state <= blockMode ? ST_CNT : ST_WDATA;
            end
          end
          ST_CNT_ACK, ST_WDATA_ACK: begin
            if (sclFall) begin
              sdaOe <= 1'b0;
              state <= ST_WDATA;
            end
          end
          ST_RD: begin
            if (sclRise) begin
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall) begin
              if (byteIn) begin
                bitCnt      <= '0;
                sdaOe       <= 1'b0;
                strb.ptrInc <= rdIsData;
                state       <= ST_RD_ACK;
              end else begin
                txShift <= {txShift[6:0], 1'b0};
                sdaOe   <= ~txShift[6];
              end
            end
          end
          ST_RD_ACK: begin
            if (sclRise && sdaLvl) begin
              state <= ST_HOLD;
            end else if (sclFall) begin
              txShift  <= rdByte;
              sdaOe    <= ~rdByte[7];
              rdIsData <= 1'b1;
              state    <= ST_RD;
            end
          end
          default: begin
            sdaOe <= 1'b0;
          end
        endcase
      end
    end
  end

  // R10: the data driver only moves right after an SCL fall, a start or a stop.
  a_r10_oe_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> $past(sclFall || startDet || stopDet));

  // R1: no drive while idle or ignoring a foreign transfer.
  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE || state == ST_HOLD) |-> !sdaOe);

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import clkcfg_pkg::*;
#(
  parameter int REG_COUNT = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   strb,
  input  logic [1:0]                strapSel,
  input  logic [7:0]                idByte,
  output logic [7:0]                rdByte,
  output logic [REG_COUNT-1:0][7:0] bank
);

  localparam int               IDX_W   = $clog2(REG_COUNT);
  localparam logic [PTR_W-1:0] PTR_MAX = '1;
  localparam logic [PTR_W-1:0] LAST_RW = PTR_W'(REG_COUNT - 2);
  localparam logic [PTR_W-1:0] ID_OFF  = PTR_W'(REG_COUNT - 1);

  logic [PTR_W-1:0] ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strb.ptrLoad) begin
      ptr <= strb.ptrVal;
    end else if (strb.ptrInc && ptr != PTR_MAX) begin
      ptr <= ptr + 1'b1;
    end
  end

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_byte
    if (i == 0) begin : g_strap
      assign bank[i] = {6'b0, strapSel};
    end else if (i == REG_COUNT - 1) begin : g_id
      assign bank[i] = idByte;
    end else begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          q <= regDefault(i);
        end else if (strb.regWr && ptr == PTR_W'(i)) begin
          q <= strb.wrData;
        end
      end
      assign bank[i] = q;
    end
  end

  always_comb begin
    if (ptr < PTR_W'(REG_COUNT)) rdByte = bank[ptr[IDX_W-1:0]];
    else                         rdByte = 8'h00;
  end

  // R3: sequential access steps the pointer by exactly one.
  a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ptrInc && !strb.ptrLoad && ptr != PTR_MAX) |=> ptr == $past(ptr) + 1'b1);

  // R2: a write to a writable offset lands there.
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    (strb.regWr && ptr >= PTR_W'(1) && ptr <= LAST_RW)
      |=> bank[$past(ptr[IDX_W-1:0])] == $past(strb.wrData));

  // R7: writes to read-only or missing offsets leave every writable byte alone.
  a_r7_ro_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strb.regWr && (ptr == '0 || ptr >= ID_OFF)) |=> $stable(bank[REG_COUNT-2:1]));

endmodule

// File: rtl/clkcfg_smbus_slave.sv
module clkcfg_smbus_slave
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h69,
  parameter int         REG_COUNT   = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  input  logic [1:0] strapSel,
  input  logic [7:0] idByte,
  output logic [3:0] hostEn,
  output logic       serRefEn,
  output logic [4:0] midEn,
  output logic       midAltSel,
  output logic [6:0] busEn,
  output logic [2:0] busFreeEn,
  output logic [1:0] refEn,
  output logic       usb48En,
  output logic       pix48En,
  output logic       serRefStopEn,
  output logic [2:0] busFreeStopEn,
  output logic       busSwStop,
  output logic       serRefStopTri,
  output logic       serRefPdTri,
  output logic [2:0] hostPdTri,
  output logic       usb48NormDrive,
  output logic       spreadOn,
  output logic       serRefFast,
  output logic       strapTestMode,
  output logic       testClkMode
);

  localparam logic [7:0] BLOCK_COUNT = 8'(REG_COUNT);

  logic sclLvl, sdaLvl, sclRise, sclFall, startDet, stopDet;
  strobe_t strb;
  logic [7:0] rdByte;
  logic [REG_COUNT-1:0][7:0] bank;
  logic unusedBits;

  smb_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  smb_ctrl #(.SLAVE_ADDR(SLAVE_ADDR), .BLOCK_COUNT(BLOCK_COUNT)) ctrl_i (
    .clk(clk), .rstN(rstN), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .rdByte(rdByte), .strb(strb), .sdaOe(sdaOe)
  );

  cfg_reg_bank #(.REG_COUNT(REG_COUNT)) bank_i (
    .clk(clk), .rstN(rstN), .strb(strb), .strapSel(strapSel), .idByte(idByte),
    .rdByte(rdByte), .bank(bank)
  );

  // Field decode.
  assign serRefStopEn   = bank[1][7];
  assign serRefEn       = bank[1][6];
  assign hostEn         = {bank[5][6], bank[1][2:0]};
  assign serRefPdTri    = bank[2][7];
  assign serRefStopTri  = bank[2][6];
  assign hostPdTri      = bank[2][5:3];
  assign busSwStop      = bank[3][7];
  assign busEn          = bank[3][6:0];
  assign usb48NormDrive = bank[4][7];
  assign usb48En        = bank[4][6];
  assign busFreeStopEn  = bank[4][5:3];
  assign busFreeEn      = bank[4][2:0];
  assign pix48En        = bank[5][7];
  assign midAltSel      = bank[5][5];
  assign midEn          = bank[5][4:0];
  assign testClkMode    = bank[6][7];
  assign strapTestMode  = bank[6][5];
  assign serRefFast     = bank[6][4];
  assign spreadOn       = bank[6][2];
  assign refEn          = bank[6][1:0];

  assign unusedBits = ^{bank[0], bank[7], bank[1][5:3], bank[2][2:0], bank[6][6], bank[6][3], sclLvl};

endmodule

// File: tb/clkcfg_smbus_slave_tb_top.sv
`timescale 1ns/1ps
module clkcfg_smbus_slave_tb_top;

  localparam int Q = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic [1:0] strapSel = 2'b10;
  logic [7:0] idByte = 8'h08;

  logic sdaOe;
  logic [3:0] hostEn; logic serRefEn; logic [4:0] midEn; logic midAltSel;
  logic [6:0] busEn; logic [2:0] busFreeEn; logic [1:0] refEn;
  logic usb48En, pix48En, serRefStopEn; logic [2:0] busFreeStopEn;
  logic busSwStop, serRefStopTri, serRefPdTri; logic [2:0] hostPdTri;
  logic usb48NormDrive, spreadOn, serRefFast, strapTestMode, testClkMode;

  wire sdaLine = mSda & ~sdaOe;

  always #2.5 clk = ~clk;

  clkcfg_smbus_slave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .strapSel(strapSel), .idByte(idByte),
    .hostEn(hostEn), .serRefEn(serRefEn), .midEn(midEn), .midAltSel(midAltSel),
    .busEn(busEn), .busFreeEn(busFreeEn), .refEn(refEn), .usb48En(usb48En),
    .pix48En(pix48En), .serRefStopEn(serRefStopEn), .busFreeStopEn(busFreeStopEn),
    .busSwStop(busSwStop), .serRefStopTri(serRefStopTri), .serRefPdTri(serRefPdTri),
    .hostPdTri(hostPdTri), .usb48NormDrive(usb48NormDrive), .spreadOn(spreadOn),
    .serRefFast(serRefFast), .strapTestMode(strapTestMode), .testClkMode(testClkMode)
  );

  int checks = 0;
  int failures = 0;
  logic [7:0] model [8];
  logic [7:0] rdBuf [12];
  logic allAck;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; mScl = 1'b1; waitQ();
    mSda = 1'b0; waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic repStart();
    mSda = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b0; waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic busStop();
    mSda = 1'b0; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b1; waitQ(); waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; waitQ();
      mScl = 1'b1; waitQ(); waitQ();
      mScl = 1'b0; waitQ();
    end
    mSda = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    ack = ~sdaLine;
    waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic recvByte(input logic hostAck, output logic [7:0] b);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ();
      mScl = 1'b1; waitQ();
      b[i] = sdaLine;
      waitQ();
      mScl = 1'b0; waitQ();
    end
    mSda = ~hostAck; waitQ();
    mScl = 1'b1; waitQ(); waitQ();
    mScl = 1'b0; waitQ();
    mSda = 1'b1;
  endtask

  task automatic putB(input logic [7:0] b);
    logic a;
    sendByte(b, a);
    allAck &= a;
  endtask

  function automatic void modelWrite(input int off, input logic [7:0] d);
    if (off >= 1 && off <= 6) model[off] = d;
  endfunction

  task automatic writeReg(input logic [6:0] off, input logic [7:0] d);
    busStart(); putB(8'hD2); putB({1'b1, off}); putB(d); busStop();
    modelWrite(int'(off), d);
  endtask

  task automatic readReg(input logic [6:0] off, output logic [7:0] d);
    busStart(); putB(8'hD2); putB({1'b1, off});
    repStart(); putB(8'hD3); recvByte(1'b0, d); busStop();
  endtask

  task automatic blockWrite(input int n, input int seed);
    busStart(); putB(8'hD2); putB(8'h00); putB(8'(n));
    for (int j = 0; j < n; j++) begin
      putB(8'((j * 17 + seed) & 255));
      modelWrite(j, 8'((j * 17 + seed) & 255));
    end
    busStop();
  endtask

  task automatic blockRead(input int n);
    busStart(); putB(8'hD2); putB(8'h00);
    repStart(); putB(8'hD3);
    for (int j = 0; j <= n; j++) recvByte(j != n, rdBuf[j]);
    busStop();
  endtask

  task automatic checkPorts(input string tag);
    chk({tag, " R8 hostEn"}, 32'(hostEn), 32'({model[5][6], model[1][2:0]}));
    chk({tag, " R8 serRef"}, 32'({serRefStopEn, serRefEn}), 32'(model[1][7:6]));
    chk({tag, " R8 pdTri"}, 32'({serRefPdTri, serRefStopTri, hostPdTri}), 32'(model[2][7:3]));
    chk({tag, " R8 bus"}, 32'({busSwStop, busEn}), 32'(model[3]));
    chk({tag, " R8 usb/free"}, 32'({usb48NormDrive, usb48En, busFreeStopEn, busFreeEn}), 32'(model[4][7:0]));
    chk({tag, " R8 mid"}, 32'({pix48En, midAltSel, midEn}), 32'({model[5][7], model[5][5:0]} & 7'h7F) & 32'h7F
        ^ 32'({1'b0, model[5][6], 5'b0}) & 32'h0);
    chk({tag, " R8 mid5"}, 32'({pix48En, midAltSel, midEn}), 32'({model[5][7], model[5][5], model[5][4:0]}));
    chk({tag, " R8 misc"}, 32'({testClkMode, strapTestMode, serRefFast, spreadOn, refEn}),
        32'({model[6][7], model[6][5], model[6][4], model[6][2], model[6][1:0]}));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic a;
    model[0] = {6'b0, strapSel};
    for (int i = 1; i <= 6; i++) model[i] = 8'h00;
    model[1] = 8'h7F; model[2] = 8'h00; model[3] = 8'hFF;
    model[4] = 8'h47; model[5] = 8'hDF; model[6] = 8'h03;
    model[7] = idByte;
    allAck = 1'b1;

    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R6 reset state at the ports
    chk("R6 sdaOe idle", 32'(sdaOe), 32'd0);
    checkPorts("reset");

    // R6 R7 R4: readback of every offset after reset
    for (int i = 0; i < 8; i++) begin
      readReg(7'(i), d);
      chk($sformatf("R6/R7 reset read off %0d", i), 32'(d), 32'(model[i]));
    end
    readReg(7'd8, d);   chk("R7 read beyond bank off 8", 32'(d), 32'd0);
    readReg(7'd100, d); chk("R7 read beyond bank off 100", 32'(d), 32'd0);
    chk("R1 R4 acks on reads", 32'(allAck), 32'd1);

    // R2 R4: sweep byte writes over every writable offset
    for (int r = 1; r <= 6; r++) begin
      for (int k = 0; k < 3; k++) begin
        allAck = 1'b1;
        writeReg(7'(r), 8'((r * 53 + k * 91 + 7) & 255));
        readReg(7'(r), d);
        chk($sformatf("R2/R4 byte write off %0d pass %0d", r, k), 32'(d), 32'(model[r]));
        chk("R2 all bytes acked", 32'(allAck), 32'd1);
      end
    end
    checkPorts("after sweep");

    // R7: writes to read-only and missing offsets are acked and discarded
    allAck = 1'b1;
    writeReg(7'd0, 8'hAA);
    writeReg(7'd7, 8'h55);
    writeReg(7'd9, 8'h3C);
    chk("R7 ro writes acked", 32'(allAck), 32'd1);
    readReg(7'd0, d); chk("R7 byte0 unchanged", 32'(d), 32'(model[0]));
    readReg(7'd7, d); chk("R7 byte7 unchanged", 32'(d), 32'(model[7]));
    strapSel = 2'b01; model[0] = 8'h01;
    readReg(7'd0, d); chk("R7 byte0 follows strap", 32'(d), 32'h01);
    for (int i = 1; i <= 6; i++) begin
      readReg(7'(i), d);
      chk($sformatf("R7 writable off %0d untouched", i), 32'(d), 32'(model[i]));
    end

    // R3 R5: block write then block read
    allAck = 1'b1;
    blockWrite(8, 3);
    chk("R3 block write acked", 32'(allAck), 32'd1);
    blockRead(8);
    chk("R5 block count", 32'(rdBuf[0]), 32'd8);
    for (int j = 0; j < 8; j++)
      chk($sformatf("R3/R5 block byte %0d", j), 32'(rdBuf[j+1]), 32'(model[j]));
    checkPorts("after block");

    // R7: oversize block write, extra bytes acked and dropped
    allAck = 1'b1;
    blockWrite(10, 101);
    chk("R7 oversize block acked", 32'(allAck), 32'd1);
    blockRead(8);
    for (int j = 0; j < 8; j++)
      chk($sformatf("R7 oversize block byte %0d", j), 32'(rdBuf[j+1]), 32'(model[j]));

    // R1: foreign address is not acked and the transfer is ignored
    busStart(); sendByte(8'hA4, a);
    chk("R1 foreign address nack", 32'(a), 32'd0);
    sendByte(8'h81, a); chk("R1 no ack later", 32'(a), 32'd0);
    sendByte(8'h5A, a); busStop();
    readReg(7'd1, d); chk("R1 foreign write ignored", 32'(d), 32'(model[1]));
    busStart(); sendByte(8'hD4, a); busStop();
    chk("R1 neighbour address nack", 32'(a), 32'd0);

    // R9: stop after command, after a partial block, partial block read
    busStart(); putB(8'hD2); putB(8'h83); busStop();
    readReg(7'd3, d); chk("R9 stop after command", 32'(d), 32'(model[3]));
    busStart(); putB(8'hD2); putB(8'h00); putB(8'd8);
    putB(8'h11); putB(8'h22); putB(8'h33); busStop();
    model[1] = 8'h22; model[2] = 8'h33;
    for (int i = 1; i <= 4; i++) begin
      readReg(7'(i), d);
      chk($sformatf("R9 partial block off %0d", i), 32'(d), 32'(model[i]));
    end
    blockRead(2);
    chk("R9 short block read count", 32'(rdBuf[0]), 32'd8);
    chk("R9 short block read b1", 32'(rdBuf[2]), 32'(model[1]));
    chk("R10 released after stop", 32'(sdaOe), 32'd0);
    readReg(7'd6, d); chk("R9 next transfer works", 32'(d), 32'(model[6]));
    checkPorts("final");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule